// File: doc/BRIEF.md
# Sequenced Palette Colour-Table Register Port

This block holds a colour lookup table and gives a processor access to it through a small 16-byte register window. The table has 256 pixel entries and 4 overlay entries. Each entry stores an 8-bit red, an 8-bit green and an 8-bit blue value. Software first writes a colour index. It then moves through the three components of that entry, one access at a time, on a single data register. After the blue access, the index steps to the next entry on its own, so a run of consecutive entries can be loaded with an unbroken stream of writes. A second data register reaches the overlay entries, which are normally used for cursor colours. On this register only the two low bits of the index select the entry.

Reads follow the same red, green, blue sequence as writes, and both use one shared sequence position. A separate lookup port, with no side effects, gives display scanout the packed colour of any entry in the same cycle. All bus accesses are full 32-bit words. Component values travel in the top byte of the word.

Top module: `pal_dac_port`

## Requirements
- R1: A write at byte offset 0 loads the colour index from data bits 31:24 and returns the sequence position to red, even partway through a sequence.
- R2: A write at byte offset 4 stores data bits 31:24 into one component of pixel entry `index`: red first, then green, then blue. Data bits 23:0 are ignored.
- R3: A write at byte offset 12 behaves like offset 4, but it targets overlay entry 256 + (index mod 4). The pixel entry at `index` is left unchanged.
- R4: After a blue access (read or write), the index increments modulo 256 (255 wraps to 0) and the sequence position returns to red.
- R5: A read at any offset returns the current component of pixel entry `index` on `cpu_rdata[31:24]`, with bits 23:0 zero. `cpu_rvalid` is high for exactly the one cycle after the read. The sequence then advances as in R2 and R4.
- R6: Reads and writes share one sequence position. For example, a read in the red position followed by a write at offset 4 stores green.
- R7: Writes at any offset other than 0, 4 and 12 change neither the index, nor the sequence position, nor any entry.
- R8: After a synchronous active-low reset, every entry is 0x000000 except entries 255, 256 and 258, which are 0xFFFFFF. The index is 0, the position is red, and `cpu_rvalid` is low.
- R9: `scan_rgb` shows entry `scan_idx` in the same cycle as {red[23:16], green[15:8], blue[7:0]}. It is zero for an index of 260 or more. Changing `scan_idx` never alters the sequence state.
- R10: When `cpu_wr` and `cpu_rd` are high in the same cycle, the write takes effect and the read is dropped. No `cpu_rvalid` follows, and the sequence advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_addr | input | 4 | Byte offset within the register window |
| cpu_wdata | input | 32 | Write data; the component or index is in bits 31:24 |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a read |
| cpu_rdata | output | 32 | Read component in bits 31:24, with zeros below |
| scan_idx | input | 9 | Scanout lookup entry number |
| scan_rgb | output | 24 | Packed colour of the looked-up entry |

## Verification
The bench builds the block with its default values: 256 pixel entries, 4 overlay entries, 8-bit components and a 32-bit bus. At these values the index wrap from 255 to 0 is reached in a few accesses, and the overlay mapping can be driven from index values whose low two bits differ from their upper bits. The same values let every one of the 260 entries be compared against the reset pattern and against the bench's own table model after the write sequences, including the out-of-range lookup indices just above the table.

// File: rtl/pal_dac_pkg.sv
// Package: shared types for the palette register port.
// Assumes a three-component colour whose components are visited in a fixed order.
package pal_dac_pkg;

    // Sequence position within one entry's three components.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Position that follows p within one entry; blue is followed by red.
    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/dac_seq_ctrl.sv
// Module: dac_seq_ctrl
// Holds the colour index and the shared component position.
// Assumes load_en and step_en are never high together (the top decodes them that way).
module dac_seq_ctrl
    import pal_dac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step_en,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase
);

    // Index and position: load, step through components, wrap the index after blue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load_en) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (step_en) begin
            if (phase == PH_BLU) begin
                idx <= idx + 1'b1;
            end
            phase <= phase_after(phase);
        end
    end

endmodule

// File: rtl/dac_lut_store.sv
// Module: dac_lut_store
// Colour table storage: one component write port, one CPU read port and one scan read port.
// Assumes at least three overlay entries so that the reset pattern can reach entry NUM_PIX+2.
module dac_lut_store
    import pal_dac_pkg::*;
#(
    parameter int NUM_PIX = 256,
    parameter int NUM_OVL = 4,
    parameter int COMP_W  = 8,
    parameter int ENT_W   = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ENT_W-1:0]    wr_ent,
    input  phase_e              wr_phase,
    input  logic [COMP_W-1:0]   wr_val,
    input  logic [ENT_W-1:0]    cpu_ent,
    output logic [3*COMP_W-1:0] cpu_rgb,
    input  logic [ENT_W-1:0]    scan_ent,
    output logic [3*COMP_W-1:0] scan_rgb
);

    localparam int NUM_ENT = NUM_PIX + NUM_OVL;
    localparam int RGB_W   = 3 * COMP_W;

    // Entries that come out of reset white: the last pixel entry and overlay entries 0 and 2.
    function automatic bit starts_white(int e);
        return (e == NUM_PIX - 1) || (e == NUM_PIX) || (e == NUM_PIX + 2);
    endfunction

    logic [RGB_W-1:0] lut [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        localparam logic [RGB_W-1:0] INIT = starts_white(g) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
        logic             hit;
        logic [RGB_W-1:0] ent_q;

        assign hit = we && (wr_ent == ENT_W'(g));

        // One entry: reset to its pattern value, or replace the component picked by the phase.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= INIT;
            end else if (hit) begin
                case (wr_phase)
                    PH_RED:  ent_q[RGB_W-1 -: COMP_W]    <= wr_val;
                    PH_GRN:  ent_q[2*COMP_W-1 -: COMP_W] <= wr_val;
                    default: ent_q[COMP_W-1:0]           <= wr_val;
                endcase
            end
        end

        assign lut[g] = ent_q;
    end

    // CPU read port: an entry outside the table reads as black.
    always_comb begin
        cpu_rgb = '0;
        if (cpu_ent < ENT_W'(NUM_ENT)) begin
            cpu_rgb = lut[cpu_ent];
        end
    end

    // Scan read port: same rule, with no effect on any state.
    always_comb begin
        scan_rgb = '0;
        if (scan_ent < ENT_W'(NUM_ENT)) begin
            scan_rgb = lut[scan_ent];
        end
    end

endmodule

// File: rtl/pal_dac_port.sv
// Module: pal_dac_port (top)
// CPU register window of the colour table: index register, pixel data register,
// overlay data register and a registered read path. Also a side-effect-free scan lookup.
// Assumes full-word accesses, NUM_PIX and NUM_OVL powers of two, and COMP_W <= BUS_W.
module pal_dac_port
    import pal_dac_pkg::*;
#(
    parameter int NUM_PIX     = 256,
    parameter int NUM_OVL     = 4,
    parameter int COMP_W      = 8,
    parameter int BUS_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int OFS_INDEX   = 0,
    parameter int OFS_PIXEL   = 4,
    parameter int OFS_OVERLAY = 12,
    localparam int ENT_W      = $clog2(NUM_PIX + NUM_OVL),
    localparam int RGB_W      = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic              cpu_rvalid,
    output logic [BUS_W-1:0]  cpu_rdata,
    input  logic [ENT_W-1:0]  scan_idx,
    output logic [RGB_W-1:0]  scan_rgb
);

    localparam int IDX_W = $clog2(NUM_PIX);
    localparam int OVL_W = (NUM_OVL > 1) ? $clog2(NUM_OVL) : 1;
    localparam int PAD_W = BUS_W - COMP_W;

    logic              hit_index, hit_pixel, hit_overlay, rd_go, step;
    logic [IDX_W-1:0]  cur_idx;
    phase_e            cur_phase;
    logic [ENT_W-1:0]  wr_ent, rd_ent;
    logic [RGB_W-1:0]  rd_rgb;
    logic [COMP_W-1:0] rd_comp;
    logic              unused_wdata_low;

    // Address decode; a write takes priority over a read in the same cycle.
    always_comb begin
        hit_index   = cpu_wr && (cpu_addr == ADDR_W'(OFS_INDEX));
        hit_pixel   = cpu_wr && (cpu_addr == ADDR_W'(OFS_PIXEL));
        hit_overlay = cpu_wr && (cpu_addr == ADDR_W'(OFS_OVERLAY));
        rd_go       = cpu_rd && !cpu_wr;
        step        = hit_pixel || hit_overlay || rd_go;
    end

    assign unused_wdata_low = ^cpu_wdata[PAD_W-1:0];

    dac_seq_ctrl #(
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (hit_index),
        .load_val(cpu_wdata[BUS_W-1 -: IDX_W]),
        .step_en (step),
        .idx     (cur_idx),
        .phase   (cur_phase)
    );

    // Target entry: the overlay register folds the index onto the overlay block.
    always_comb begin
        if (hit_overlay) begin
            wr_ent = ENT_W'(NUM_PIX) + ENT_W'(cur_idx[OVL_W-1:0]);
        end else begin
            wr_ent = ENT_W'(cur_idx);
        end
        rd_ent = ENT_W'(cur_idx);
    end

    dac_lut_store #(
        .NUM_PIX (NUM_PIX),
        .NUM_OVL (NUM_OVL),
        .COMP_W  (COMP_W),
        .ENT_W   (ENT_W)
    ) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (hit_pixel || hit_overlay),
        .wr_ent  (wr_ent),
        .wr_phase(cur_phase),
        .wr_val  (cpu_wdata[BUS_W-1 -: COMP_W]),
        .cpu_ent (rd_ent),
        .cpu_rgb (rd_rgb),
        .scan_ent(scan_idx),
        .scan_rgb(scan_rgb)
    );

    // Component picked by the current position for a CPU read.
    always_comb begin
        case (cur_phase)
            PH_RED:  rd_comp = rd_rgb[RGB_W-1 -: COMP_W];
            PH_GRN:  rd_comp = rd_rgb[2*COMP_W-1 -: COMP_W];
            default: rd_comp = rd_rgb[COMP_W-1:0];
        endcase
    end

    // Read return register: the component sits in the top byte, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            cpu_rvalid <= rd_go;
            if (rd_go) begin
                cpu_rdata <= {rd_comp, {PAD_W{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/pal_dac_chk.sv
// Module: pal_dac_chk
// Property checker for pal_dac_port, attached with bind below.
// Assumes it sees the top's ports together with the sequence controller's outputs.
module pal_dac_chk #(
    parameter int COMP_W      = 8,
    parameter int BUS_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int IDX_W       = 8,
    parameter int OFS_INDEX   = 0,
    parameter int OFS_PIXEL   = 4,
    parameter int OFS_OVERLAY = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [BUS_W-1:0]  cpu_wdata,
    input logic              cpu_rvalid,
    input logic [BUS_W-1:0]  cpu_rdata,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [1:0]        cur_phase
);

    logic is_idx, is_data, is_other;
    assign is_idx   = cpu_addr == ADDR_W'(OFS_INDEX);
    assign is_data  = (cpu_addr == ADDR_W'(OFS_PIXEL)) || (cpu_addr == ADDR_W'(OFS_OVERLAY));
    assign is_other = !is_idx && !is_data;

    // R1: an index write loads the top byte and restarts at red.
    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && is_idx) |=> (cur_idx == $past(cpu_wdata[BUS_W-1 -: IDX_W])) && (cur_phase == 2'd0));

    // R2: the position never takes the unused encoding.
    a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cur_phase != 2'd3);

    // R4: a data write in the blue position moves to the next index and back to red.
    a_r4_blue_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && is_data && cur_phase == 2'd2) |=>
        (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == 2'd0));

    // R5: returned read data carries zeros below the component.
    a_r5_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> (cpu_rdata[BUS_W-COMP_W-1:0] == '0));

    // R5: a read alone is answered in the next cycle.
    a_r5_rvalid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    // R10: no read strobe, or a read that collides with a write, gives no valid data.
    a_r10_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !cpu_wr) |=> !cpu_rvalid);

    // R7: a write at an unused offset leaves the sequence state alone.
    a_r7_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && is_other) |=> ($stable(cur_idx) && $stable(cur_phase)));

endmodule

bind pal_dac_port pal_dac_chk #(
    .COMP_W     (COMP_W),
    .BUS_W      (BUS_W),
    .ADDR_W     (ADDR_W),
    .IDX_W      ($clog2(NUM_PIX)),
    .OFS_INDEX  (OFS_INDEX),
    .OFS_PIXEL  (OFS_PIXEL),
    .OFS_OVERLAY(OFS_OVERLAY)
) u_pal_dac_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rvalid(cpu_rvalid),
    .cpu_rdata (cpu_rdata),
    .cur_idx   (cur_idx),
    .cur_phase (cur_phase)
);

// File: tb/tb_pal_dac_port.sv
// Scoreboard bench for pal_dac_port: driver tasks keep a table model and queue
// expected read words; a monitor pops them when the design returns read data.
module tb_pal_dac_port;

    localparam int NENT = 260;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic [8:0]  scan_idx = '0;
    logic [23:0] scan_rgb;

    always #4 clk = ~clk;

    pal_dac_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rvalid(cpu_rvalid),
        .cpu_rdata (cpu_rdata),
        .scan_idx  (scan_idx),
        .scan_rgb  (scan_rgb)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_r [NENT];
    logic [7:0] m_g [NENT];
    logic [7:0] m_b [NENT];
    logic [7:0] m_idx;
    int         m_ph;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model reset pattern, written from R8.
    task automatic model_reset();
        for (int i = 0; i < NENT; i++) begin
            m_r[i] = 8'h00; m_g[i] = 8'h00; m_b[i] = 8'h00;
        end
        foreach (m_r[i]) begin
            if (i == 255 || i == 256 || i == 258) begin
                m_r[i] = 8'hFF; m_g[i] = 8'hFF; m_b[i] = 8'hFF;
            end
        end
        m_idx = 8'h00;
        m_ph  = 0;
    endtask

    function automatic logic [23:0] model_scan(int e);
        if (e >= NENT) return 24'h0;
        return {m_r[e], m_g[e], m_b[e]};
    endfunction

    // One component access on the model; returns the word a read would give.
    task automatic model_step(bit is_wr, bit ovl, logic [7:0] v, output logic [31:0] rd_word);
        int e;
        e = ovl ? 256 + int'(m_idx[1:0]) : int'(m_idx);
        rd_word = 32'h0;
        if (is_wr) begin
            if (m_ph == 0) m_r[e] = v;
            else if (m_ph == 1) m_g[e] = v;
            else m_b[e] = v;
        end else begin
            if (m_ph == 0) rd_word = {m_r[e], 24'h0};
            else if (m_ph == 1) rd_word = {m_g[e], 24'h0};
            else rd_word = {m_b[e], 24'h0};
        end
        if (m_ph == 2) begin
            m_ph = 0;
            m_idx = m_idx + 8'd1;
        end else begin
            m_ph++;
        end
    endtask

    task automatic model_write(logic [3:0] a, logic [7:0] v);
        logic [31:0] unused_w;
        if (a == 4'd0) begin
            m_idx = v; m_ph = 0;
        end else if (a == 4'd4) begin
            model_step(1'b1, 1'b0, v, unused_w);
        end else if (a == 4'd12) begin
            model_step(1'b1, 1'b1, v, unused_w);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Driver: a write with junk in the low bits, which R2 says are ignored.
    task automatic bus_write(logic [3:0] a, logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = {v, 24'hA5C31E};
        model_write(a, v);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // Driver: a read; the expected word goes to the scoreboard.
    task automatic bus_read(logic [3:0] a, string req);
        logic [31:0] w;
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        model_step(1'b0, 1'b0, 8'h00, w);
        exp_q.push_back(w);
        tag_q.push_back(req);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // Driver: read and write in the same cycle (R10: the write wins).
    task automatic bus_both(logic [3:0] a, logic [7:0] v);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_addr = a; cpu_wdata = {v, 24'h0};
        model_write(a, v);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        #1;
        check(cpu_rvalid == 1'b0, "R10 no rvalid after collision", 32'(cpu_rvalid), 32'h0);
    endtask

    task automatic scan_chk(int e, string req);
        scan_idx = 9'(e);
        #1;
        check(scan_rgb == model_scan(e), req, 32'(scan_rgb), 32'(model_scan(e)));
    endtask

    task automatic scan_all(string req);
        for (int i = 0; i < NENT; i++) scan_chk(i, req);
    endtask

    // Monitor: compare each returned read against the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected rvalid", cpu_rdata, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cpu_rdata == e, t, cpu_rdata, e);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: reset state.
        check(cpu_rvalid == 1'b0, "R8 rvalid low after reset", 32'(cpu_rvalid), 32'h0);
        scan_all("R8 reset table");
        // R5 and R8: reads at mixed offsets start at index 0, red.
        bus_read(4'd0, "R5 read entry0 red");
        bus_read(4'd8, "R5 read entry0 green");
        bus_read(4'd4, "R5 read entry0 blue");

        // R2: load entry 5, then read it back (R5).
        bus_write(4'd0, 8'd5);
        bus_write(4'd4, 8'h11);
        bus_write(4'd4, 8'h22);
        bus_write(4'd4, 8'h33);
        scan_chk(5, "R2 entry5 written");
        bus_write(4'd0, 8'd5);
        bus_read(4'd4, "R5 entry5 red");
        bus_read(4'd4, "R5 entry5 green");
        bus_read(4'd4, "R5 entry5 blue");

        // R1: an index write mid-sequence returns to red.
        bus_write(4'd0, 8'd9);
        bus_write(4'd4, 8'h44);
        bus_write(4'd0, 8'd9);
        bus_write(4'd4, 8'h55);
        scan_chk(9, "R1 phase reset by index write");

        // R3: overlay writes fold index 7 onto entry 259; pixel entry 7 stays black.
        bus_write(4'd0, 8'd7);
        bus_write(4'd12, 8'h10);
        bus_write(4'd12, 8'h20);
        bus_write(4'd12, 8'h30);
        scan_chk(259, "R3 overlay entry 259");
        scan_chk(7, "R3 pixel entry 7 untouched");
        // R4: index advanced to 8 after the overlay blue.
        bus_write(4'd4, 8'h99);
        scan_chk(8, "R4 index advanced to 8");
        bus_write(4'd0, 8'hFE);
        bus_write(4'd12, 8'h01);
        bus_write(4'd12, 8'h02);
        bus_write(4'd12, 8'h03);
        scan_chk(258, "R3 overlay entry 258");

        // R4: wrap from 255 to 0.
        bus_write(4'd0, 8'd0);
        bus_write(4'd4, 8'hAB);
        bus_write(4'd4, 8'hCD);
        bus_write(4'd4, 8'hEF);
        bus_write(4'd0, 8'd255);
        bus_write(4'd4, 8'h01);
        bus_write(4'd4, 8'h02);
        bus_write(4'd4, 8'h03);
        scan_chk(255, "R4 entry 255");
        bus_read(4'd4, "R4 wrap read entry0 red");
        bus_read(4'd4, "R4 wrap read entry0 green");
        bus_read(4'd4, "R4 wrap read entry0 blue");

        // R6: a read in red, then a write, stores green.
        bus_write(4'd0, 8'd20);
        bus_read(4'd4, "R6 read red of entry20");
        bus_write(4'd4, 8'h77);
        scan_chk(20, "R6 write after read hit green");
        bus_read(4'd4, "R6 read blue of entry20");

        // R7: unused offsets change nothing.
        bus_write(4'd0, 8'd30);
        bus_write(4'd4, 8'h12);
        bus_write(4'd8, 8'hFF);
        bus_write(4'd2, 8'hFF);
        bus_write(4'd15, 8'hFF);
        bus_write(4'd4, 8'h34);
        bus_write(4'd4, 8'h56);
        scan_chk(30, "R7 sequence intact over ignored writes");
        scan_all("R7 table after ignored writes");

        // R9: sweeping the scan port leaves the sequence alone; out of range reads zero.
        bus_write(4'd0, 8'd40);
        bus_write(4'd4, 8'h61);
        scan_all("R9 scan sweep");
        scan_chk(260, "R9 index 260 reads zero");
        scan_chk(511, "R9 index 511 reads zero");
        bus_write(4'd4, 8'h62);
        bus_write(4'd4, 8'h63);
        scan_chk(40, "R9 sequence undisturbed by scan");

        // R10: collision: write applied, read dropped, one step only.
        bus_write(4'd0, 8'd50);
        bus_both(4'd4, 8'h70);
        scan_chk(50, "R10 colliding write applied");
        bus_read(4'd4, "R10 next read is green");

        // R8: reset in mid-sequence restores the pattern.
        bus_write(4'd0, 8'd60);
        bus_write(4'd4, 8'h88);
        apply_reset();
        #1;
        scan_all("R8 table after second reset");
        bus_read(4'd4, "R8 index and phase after reset");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all reads answered", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule